// File: doc/BRIEF.md
# Low-Water-Mark Stream Buffer Controller

This block sits between a network interface that delivers media data in bursts and a playback consumer that drains it at a steady rate. It stores the data in a FIFO and switches the network interface off once the FIFO is full. Playback keeps reading from the buffer while the interface is off. When the fill level sinks to a programmable low-water mark, the controller powers the interface up again. It waits a programmable wakeup delay, pulses a refill request towards the server and then lets the interface fill the buffer until it is full again.

The low-water mark sets the balance between power and safety. A low mark gives long off periods but leaves little margin against running dry. A high mark is safer but pays the cost of turning the interface on and off more often. The mark is kept between a floor and a ceiling. The floor covers the time it takes to wake the interface and issue a request. The ceiling is one block below the buffer depth. Any value loaded outside that range is clamped to the nearest bound.

Top module: `lwm_stream_buf`

## Requirements
- R1: While reset is asserted, level is 0, nic_on is 0, refill_req is 0, rd_valid is 0, underflow is 0 and mark equals MIN_MARK.
- R2: Accepted words are read back in write order. A read on a non-empty buffer presents the word on rd_data with rd_valid high in the cycle after rd_en.
- R3: A write while level equals DEPTH is refused. Level stays at DEPTH and the stored words are unchanged.
- R4: A read while level is 0 returns no data (rd_valid stays low) and sets underflow. Underflow then stays high until reset.
- R5: While nic_on is high and level equals DEPTH, nic_on goes low at the next clock edge. Reads are still served while nic_on is low.
- R6: While nic_on is low and level is at or below mark, nic_on goes high at the next clock edge. While level is above mark, nic_on stays low.
- R7: After nic_on rises, refill_req goes high for exactly one cycle, wake_dly+1 cycles later. nic_on then stays high until the buffer is full.
- R8: A mark_load strobe loads mark_val into mark on the next edge. Values below MIN_MARK become MIN_MARK, and values above DEPTH-BLOCK become DEPTH-BLOCK. Without the strobe, mark holds its value.
- R9: Level counts the stored words and moves by at most one per cycle. A read and a write in the same cycle on a buffer that is neither empty nor full leave level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe from the network side |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | Buffer full; writes are refused |
| rd_en | input | 1 | Read strobe from the playback side |
| rd_data | output | DATA_W | Word read, valid with rd_valid |
| rd_valid | output | 1 | rd_data carries a word this cycle |
| underflow | output | 1 | Sticky flag for a read on an empty buffer |
| level | output | $clog2(DEPTH+1) | Words currently stored |
| mark_load | input | 1 | Load strobe for the low-water mark |
| mark_val | input | $clog2(DEPTH+1) | Requested low-water mark |
| mark | output | $clog2(DEPTH+1) | Low-water mark in force (after clamping) |
| wake_dly | input | WAKE_W | Wakeup delay in cycles |
| nic_on | output | 1 | Power enable for the network interface |
| refill_req | output | 1 | One-cycle refill request pulse |

## Verification
The bench builds the block with DEPTH 16, BLOCK 4, MIN_MARK 3, an 8-bit word and a wakeup delay of 2. These values keep a full fill-and-drain cycle down to a few dozen clocks. In that time the off-at-full transition, the wake at the mark of 3, the request pulse three cycles after wakeup, and the full and empty refusals are all reached. With a 5-bit mark field, both clamp bounds (3 and 12) and an in-range value can be loaded directly.

// File: rtl/lwm_pkg.sv
`timescale 1ns/1ps
package lwm_pkg;
    typedef enum logic [1:0] {
        PS_OFF  = 2'd0,
        PS_WAKE = 2'd1,
        PS_REQ  = 2'd2,
        PS_FILL = 2'd3
    } pwr_state_t;
endpackage

// File: rtl/lwm_fifo.sv
`timescale 1ns/1ps
module lwm_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         rd_en,
    output logic [DATA_W-1:0]            rd_data,
    output logic                         rd_valid,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         full,
    output logic                         underflow
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             wp;
        logic [PTR_W-1:0]             rp;
        logic [CNT_W-1:0]             cnt;
        logic [DATA_W-1:0]            rdat;
        logic                         rv;
        logic                         uf;
    } fifo_s;

    fifo_s q, d;
    logic  is_full, is_empty, do_wr, do_rd;

    always_comb begin
        d        = q;
        d.rv     = 1'b0;
        is_full  = (q.cnt == CNT_W'(DEPTH));
        is_empty = (q.cnt == '0);
        do_wr    = wr_en && !is_full;
        do_rd    = rd_en && !is_empty;
        if (do_wr) begin
            d.mem[q.wp] = wr_data;
            d.wp        = (q.wp == PTR_W'(DEPTH - 1)) ? '0 : q.wp + 1'b1;
        end
        if (do_rd) begin
            d.rdat = q.mem[q.rp];
            d.rv   = 1'b1;
            d.rp   = (q.rp == PTR_W'(DEPTH - 1)) ? '0 : q.rp + 1'b1;
        end
        if (rd_en && is_empty) begin
            d.uf = 1'b1;
        end
        case ({do_wr, do_rd})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_data   = q.rdat;
    assign rd_valid  = q.rv;
    assign level     = q.cnt;
    assign full      = (q.cnt == CNT_W'(DEPTH));
    assign underflow = q.uf;
endmodule

// File: rtl/lwm_mark_reg.sv
`timescale 1ns/1ps
module lwm_mark_reg #(
    parameter int CNT_W    = 5,
    parameter int MIN_MARK = 3,
    parameter int MAX_MARK = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] val,
    output logic [CNT_W-1:0] mark
);
    logic [CNT_W-1:0] mark_q, mark_d;

    always_comb begin
        mark_d = mark_q;
        if (load) begin
            if (val < CNT_W'(MIN_MARK))      mark_d = CNT_W'(MIN_MARK);
            else if (val > CNT_W'(MAX_MARK)) mark_d = CNT_W'(MAX_MARK);
            else                             mark_d = val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mark_q <= CNT_W'(MIN_MARK);
        else        mark_q <= mark_d;
    end

    assign mark = mark_q;
endmodule

// File: rtl/lwm_radio_fsm.sv
`timescale 1ns/1ps
module lwm_radio_fsm
    import lwm_pkg::*;
#(
    parameter int CNT_W  = 5,
    parameter int WAKE_W = 4,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  level,
    input  logic [CNT_W-1:0]  mark,
    input  logic [WAKE_W-1:0] wake_dly,
    output logic              nic_on,
    output logic              refill_req
);
    typedef struct packed {
        pwr_state_t        st;
        logic [WAKE_W-1:0] cnt;
    } fsm_s;

    fsm_s q, d;

    always_comb begin
        d = q;
        case (q.st)
            PS_OFF: begin
                if (level <= mark) begin
                    d.st  = PS_WAKE;
                    d.cnt = wake_dly;
                end
            end
            PS_WAKE: begin
                if (q.cnt == '0) d.st  = PS_REQ;
                else             d.cnt = q.cnt - 1'b1;
            end
            PS_REQ:  d.st = PS_FILL;
            default: d.st = PS_FILL;
        endcase
        if (q.st != PS_OFF && level == CNT_W'(DEPTH)) begin
            d.st = PS_OFF;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: PS_OFF, cnt: '0};
        else        q <= d;
    end

    assign nic_on     = (q.st != PS_OFF);
    assign refill_req = (q.st == PS_REQ);
endmodule

// File: rtl/lwm_stream_buf.sv
`timescale 1ns/1ps
module lwm_stream_buf #(
    parameter int DATA_W   = 8,
    parameter int DEPTH    = 16,
    parameter int BLOCK    = 4,
    parameter int MIN_MARK = 3,
    parameter int WAKE_W   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [DATA_W-1:0]          wr_data,
    output logic                       wr_full,
    input  logic                       rd_en,
    output logic [DATA_W-1:0]          rd_data,
    output logic                       rd_valid,
    output logic                       underflow,
    output logic [$clog2(DEPTH+1)-1:0] level,
    input  logic                       mark_load,
    input  logic [$clog2(DEPTH+1)-1:0] mark_val,
    output logic [$clog2(DEPTH+1)-1:0] mark,
    input  logic [WAKE_W-1:0]          wake_dly,
    output logic                       nic_on,
    output logic                       refill_req
);
    localparam int CNT_W    = $clog2(DEPTH + 1);
    localparam int MAX_MARK = DEPTH - BLOCK;

    lwm_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .level     (level),
        .full      (wr_full),
        .underflow (underflow)
    );

    lwm_mark_reg #(.CNT_W(CNT_W), .MIN_MARK(MIN_MARK), .MAX_MARK(MAX_MARK)) u_mark (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (mark_load),
        .val   (mark_val),
        .mark  (mark)
    );

    lwm_radio_fsm #(.CNT_W(CNT_W), .WAKE_W(WAKE_W), .DEPTH(DEPTH)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .level      (level),
        .mark       (mark),
        .wake_dly   (wake_dly),
        .nic_on     (nic_on),
        .refill_req (refill_req)
    );
endmodule

// File: rtl/lwm_stream_buf_chk.sv
`timescale 1ns/1ps
module lwm_stream_buf_chk #(
    parameter int DEPTH    = 16,
    parameter int BLOCK    = 4,
    parameter int MIN_MARK = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic                       rd_en,
    input logic                       rd_valid,
    input logic                       underflow,
    input logic [$clog2(DEPTH+1)-1:0] level,
    input logic [$clog2(DEPTH+1)-1:0] mark,
    input logic                       nic_on,
    input logic                       refill_req
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    AST_FULL_WRITE_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (level == CNT_W'(DEPTH) && wr_en && !rd_en) |=> (level == CNT_W'(DEPTH))); // R3

    AST_EMPTY_READ_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0 && rd_en) |=> (!rd_valid && underflow)); // R4

    AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow); // R4

    AST_OFF_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (nic_on && level == CNT_W'(DEPTH)) |=> !nic_on); // R5

    AST_WAKE_AT_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (!nic_on && level <= mark) |=> nic_on); // R6

    AST_STAY_OFF_ABOVE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (!nic_on && level > mark) |=> !nic_on); // R6

    AST_REQ_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        refill_req |=> !refill_req); // R7

    AST_REQ_ONLY_WHEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
        refill_req |-> nic_on); // R7

    AST_MARK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (mark >= CNT_W'(MIN_MARK)) && (mark <= CNT_W'(DEPTH - BLOCK))); // R8

    AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (level == $past(level)) || (level == $past(level) + CNT_W'(1))
        || (level + CNT_W'(1) == $past(level))); // R9

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CNT_W'(DEPTH)); // R9
endmodule

bind lwm_stream_buf lwm_stream_buf_chk #(
    .DEPTH(DEPTH), .BLOCK(BLOCK), .MIN_MARK(MIN_MARK)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .rd_valid   (rd_valid),
    .underflow  (underflow),
    .level      (level),
    .mark       (mark),
    .nic_on     (nic_on),
    .refill_req (refill_req)
);

// File: tb/sim_lwm_stream_buf.sv
`timescale 1ns/1ps
module sim_lwm_stream_buf;
    localparam int DATA_W   = 8;
    localparam int DEPTH    = 16;
    localparam int BLOCK    = 4;
    localparam int MIN_MARK = 3;
    localparam int WAKE_W   = 4;
    localparam int CNT_W    = $clog2(DEPTH + 1);
    localparam int NVEC     = 10;

    // {wr, rd, wdata[8], exp_level[5], exp_rv, exp_rdata[8]}
    localparam logic [23:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 8'hA0, 5'd1, 1'b0, 8'h00},
        {1'b1, 1'b0, 8'hA1, 5'd2, 1'b0, 8'h00},
        {1'b1, 1'b0, 8'hA2, 5'd3, 1'b0, 8'h00},
        {1'b0, 1'b1, 8'h00, 5'd2, 1'b1, 8'hA0},
        {1'b1, 1'b1, 8'hA3, 5'd2, 1'b1, 8'hA1},
        {1'b0, 1'b1, 8'h00, 5'd1, 1'b1, 8'hA2},
        {1'b0, 1'b1, 8'h00, 5'd0, 1'b1, 8'hA3},
        {1'b0, 1'b1, 8'h00, 5'd0, 1'b0, 8'h00},
        {1'b1, 1'b1, 8'hB0, 5'd1, 1'b0, 8'h00},
        {1'b0, 1'b1, 8'h00, 5'd0, 1'b1, 8'hB0}
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              wr_en, rd_en, mark_load;
    logic [DATA_W-1:0] wr_data;
    logic [CNT_W-1:0]  mark_val;
    logic [WAKE_W-1:0] wake_dly;
    logic              wr_full, rd_valid, underflow, nic_on, refill_req;
    logic [DATA_W-1:0] rd_data;
    logic [CNT_W-1:0]  level, mark;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    lwm_stream_buf #(
        .DATA_W(DATA_W), .DEPTH(DEPTH), .BLOCK(BLOCK),
        .MIN_MARK(MIN_MARK), .WAKE_W(WAKE_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_full(wr_full), .rd_en(rd_en), .rd_data(rd_data),
        .rd_valid(rd_valid), .underflow(underflow), .level(level),
        .mark_load(mark_load), .mark_val(mark_val), .mark(mark),
        .wake_dly(wake_dly), .nic_on(nic_on), .refill_req(refill_req)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
        mark_load = 1'b0; mark_val = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle_inputs();
        repeat (3) step();
        chk("R1", "level",      int'(level),      0);
        chk("R1", "nic_on",     int'(nic_on),     0);
        chk("R1", "refill_req", int'(refill_req), 0);
        chk("R1", "rd_valid",   int'(rd_valid),   0);
        chk("R1", "underflow",  int'(underflow),  0);
        chk("R1", "mark",       int'(mark),       MIN_MARK);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        wake_dly = 4'd2;
        do_reset();

        // Table walk: order, simultaneous read/write, empty reads (R2, R9, R4)
        for (int i = 0; i < NVEC; i++) begin
            wr_en   = VEC[i][23];
            rd_en   = VEC[i][22];
            wr_data = VEC[i][21:14];
            step();
            chk("R9", "level", int'(level), int'(VEC[i][13:9]));
            chk("R2", "rd_valid", int'(rd_valid), int'(VEC[i][8]));
            if (VEC[i][8]) chk("R2", "rd_data", int'(rd_data), int'(VEC[i][7:0]));
        end
        idle_inputs();
        step();
        chk("R4", "underflow sticky", int'(underflow), 1);

        // Power sequencing after a fresh reset, wake_dly = 2
        do_reset();
        step();
        chk("R6", "nic_on after reset at level 0", int'(nic_on), 1);
        chk("R7", "refill_req during wake", int'(refill_req), 0);
        step();
        chk("R7", "refill_req during wake", int'(refill_req), 0);
        step();
        chk("R7", "refill_req during wake", int'(refill_req), 0);
        step();
        chk("R7", "refill_req pulse", int'(refill_req), 1);
        step();
        chk("R7", "refill_req end", int'(refill_req), 0);
        chk("R7", "nic_on while filling", int'(nic_on), 1);

        // Fill to full
        for (int i = 0; i < DEPTH; i++) begin
            wr_en   = 1'b1;
            wr_data = DATA_W'(8'h10 + i);
            step();
            chk("R7", "nic_on until full", int'(nic_on), 1);
        end
        chk("R9", "level at full", int'(level), DEPTH);
        chk("R3", "wr_full", int'(wr_full), 1);

        // Refused write on full buffer
        wr_data = 8'hEE;
        step();
        wr_en = 1'b0;
        chk("R3", "level after refused write", int'(level), DEPTH);
        chk("R5", "nic_on off at full", int'(nic_on), 0);

        // Drain while off; wake once level reaches mark (3)
        for (int i = 0; i < DEPTH; i++) begin
            rd_en = 1'b1;
            step();
            chk("R3", "rd_data order kept", int'(rd_data), 8'h10 + i);
            chk("R5", "rd_valid while off", int'(rd_valid), 1);
            chk("R6", "nic_on vs mark", int'(nic_on), ((DEPTH - 1 - i) < MIN_MARK) ? 1 : 0);
        end
        step();
        chk("R4", "rd_valid on empty", int'(rd_valid), 0);
        chk("R4", "underflow set", int'(underflow), 1);
        rd_en = 1'b0;
        repeat (3) step();
        chk("R4", "underflow held", int'(underflow), 1);

        // Mark clamping
        mark_load = 1'b1; mark_val = CNT_W'(0);
        step();
        chk("R8", "mark low clamp", int'(mark), MIN_MARK);
        mark_val = CNT_W'(15);
        step();
        chk("R8", "mark high clamp", int'(mark), DEPTH - BLOCK);
        mark_val = CNT_W'(7);
        step();
        chk("R8", "mark in range", int'(mark), 7);
        mark_load = 1'b0; mark_val = CNT_W'(1);
        step();
        chk("R8", "mark held without strobe", int'(mark), 7);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule